// File: doc/BRIEF.md
# Indexed Effective-Address Unit

This unit turns one indexed-mode postbyte into a 16-bit effective address. When `start` is raised, it takes a snapshot of the postbyte, the four base registers, both accumulators and the program counter. The program counter must already point at the byte that follows the postbyte.

If the mode needs one or two offset bytes, the unit reads them from memory at the program counter and steps the counter past them. It then forms the intermediate address. In an indirect mode it also reads a big-endian 16-bit pointer at that address. All memory traffic uses a byte-wide request/valid port.

The unit reports its result in a single-cycle `done` pulse. In that cycle it presents the final address, the updated program counter, any auto-increment or auto-decrement write-back for the base register, and a flag that marks an illegal postbyte. The instruction decoder that feeds the unit and the data access that uses the address are built elsewhere.

Top module: `idx_ea_unit`

## Requirements
- R1: Postbyte bits 6:5 choose the base register (00 X, 01 Y, 10 U, 11 S). With bit 7 clear, bits 4:0 are a two's-complement offset added to the base, with no memory read and no write-back.
- R2: With bit 7 set, mode (bits 3:0) 0100 adds zero, 0101 adds B sign-extended, 0110 adds A sign-extended, and 1011 adds the 16-bit value A:B (A high).
- R3: Mode 1000 reads one offset byte at the program counter and sign-extends it. Mode 1001 reads two bytes, the high byte at the program counter and the low byte at the next address. `pc_out` equals `pc_in` plus the number of offset bytes read.
- R4: Modes 1100 and 1101 take their offset like 1000 and 1001, but add it to the program counter value after the offset bytes. Bits 6:5 have no effect in these modes.
- R5: Modes 0000 and 0001 use the old base as the address and write back base+1 or base+2. Modes 0010 and 0011 write back base−1 or base−2 and use that new value as the address. `wb_en` is high only in the `done` cycle, and `wb_sel` repeats bits 6:5.
- R6: With bit 7 and bit 4 set, the effective address is the 16-bit word read from the intermediate address, high byte at that address and low byte at the next.
- R7: Postbyte 0x9F reads a two-byte address at the program counter, high byte first, and then reads the effective address from that location.
- R8: Modes 0111, 1010 and 1110, mode 1111 in any postbyte other than 0x9F, and postbytes 0x90/0xB0/0xD0/0xF0/0x92/0xB2/0xD2/0xF2 are illegal. For these the unit raises `illegal` together with `done`, makes no memory request and no write-back, and leaves `pc_out` equal to `pc_in`.
- R9: `done` lasts exactly one cycle. A `start` that arrives while an operation is in progress is ignored. While `mem_req` waits for `mem_valid`, `mem_addr` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address computation (sampled only when idle) |
| postbyte | input | 8 | Indexed-mode postbyte |
| reg_x | input | 16 | Base register X |
| reg_y | input | 16 | Base register Y |
| reg_u | input | 16 | Base register U |
| reg_s | input | 16 | Base register S |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc_in | input | 16 | Address of the byte after the postbyte |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_valid | input | 1 | Read data is valid this cycle |
| mem_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address, valid with done |
| illegal | output | 1 | Postbyte illegal, valid with done |
| pc_out | output | 16 | Program counter after offset bytes, valid with done |
| wb_en | output | 1 | Base register write-back strobe |
| wb_sel | output | 2 | Base register to write (same code as bits 6:5) |
| wb_val | output | 16 | Value to write back |

## Verification
Two events can land in the same cycle: the base-register write-back, and the completion that follows the pointer read in the indirect auto-increment and auto-decrement modes (0x91, 0x93 and their Y/U/S forms). The bench provokes this overlap with directed postbytes and with random postbytes, and it inserts random memory latency so the pointer read ends at varying times. At the `done` cycle it compares the write-back value, the selected register and the pointer-derived address against its own model. It also checks that `wb_en` stays low in every other cycle.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int AW    = 16;
  localparam int BW    = 8;
  localparam int NBASE = 4;
  localparam int SELW  = $clog2(NBASE);

  typedef enum logic [2:0] {
    ADD_ZERO, ADD_C5, ADD_A, ADD_B, ADD_D, ADD_OFS, ADD_EXT
  } add_e;

  typedef enum logic [2:0] {
    WB_NONE, WB_INC1, WB_INC2, WB_DEC1, WB_DEC2
  } wb_e;

  typedef struct packed {
    logic       illegal;
    logic [1:0] nbytes;
    logic       indirect;
    logic       pc_rel;
    add_e       add;
    wb_e        wb;
  } dec_t;

  function automatic logic [AW-1:0] sext_byte(input logic [BW-1:0] v);
    return {{(AW-BW){v[BW-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] sext_five(input logic [4:0] v);
    return {{(AW-5){v[4]}}, v};
  endfunction

  // New base register value after the auto step
  function automatic logic [AW-1:0] step_base(input logic [AW-1:0] b, input wb_e w);
    case (w)
      WB_INC1: return b + AW'(1);
      WB_INC2: return b + AW'(2);
      WB_DEC1: return b - AW'(1);
      WB_DEC2: return b - AW'(2);
      default: return b;
    endcase
  endfunction

  // Pre-decrement modes address with the new value, others with the old one
  function automatic logic [AW-1:0] auto_addr(input logic [AW-1:0] b, input wb_e w);
    if (w == WB_DEC1 || w == WB_DEC2) return step_base(b, w);
    return b;
  endfunction
endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_ea_pkg::*;
(
  input  logic [7:0] pb,
  output dec_t       dec
);
  logic [3:0] mode;
  logic       ind;
  assign mode = pb[3:0];
  assign ind  = pb[4];

  always_comb begin
    dec = '{illegal: 1'b0, nbytes: 2'd0, indirect: 1'b0, pc_rel: 1'b0,
            add: ADD_ZERO, wb: WB_NONE};
    if (!pb[7]) begin
      dec.add = ADD_C5;
    end else begin
      dec.indirect = ind;
      case (mode)
        4'b0000: begin dec.wb = WB_INC1; dec.illegal = ind; end
        4'b0001: dec.wb = WB_INC2;
        4'b0010: begin dec.wb = WB_DEC1; dec.illegal = ind; end
        4'b0011: dec.wb = WB_DEC2;
        4'b0100: dec.add = ADD_ZERO;
        4'b0101: dec.add = ADD_B;
        4'b0110: dec.add = ADD_A;
        4'b1011: dec.add = ADD_D;
        4'b1000: begin dec.add = ADD_OFS; dec.nbytes = 2'd1; end
        4'b1001: begin dec.add = ADD_OFS; dec.nbytes = 2'd2; end
        4'b1100: begin dec.add = ADD_OFS; dec.nbytes = 2'd1; dec.pc_rel = 1'b1; end
        4'b1101: begin dec.add = ADD_OFS; dec.nbytes = 2'd2; dec.pc_rel = 1'b1; end
        4'b1111: begin
          if (pb[6:4] == 3'b001) begin
            dec.add = ADD_EXT; dec.nbytes = 2'd2;
          end else begin
            dec.illegal = 1'b1;
          end
        end
        default: dec.illegal = 1'b1;
      endcase
      if (dec.illegal) begin
        dec.nbytes = 2'd0; dec.wb = WB_NONE; dec.indirect = 1'b0;
      end
    end
  end
endmodule

// File: rtl/idx_base_sel.sv
module idx_base_sel
  import idx_ea_pkg::*;
(
  input  logic [NBASE*AW-1:0] regs_flat,
  input  logic [SELW-1:0]     sel,
  output logic [AW-1:0]       base
);
  logic [AW-1:0] bank [NBASE];

  for (genvar g = 0; g < NBASE; g++) begin : g_slice
    assign bank[g] = regs_flat[g*AW +: AW];
  end

  assign base = bank[sel];
endmodule

// File: rtl/idx_ea_adder.sv
module idx_ea_adder
  import idx_ea_pkg::*;
(
  input  dec_t           dec,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  pc,
  input  logic [BW-1:0]  acc_a,
  input  logic [BW-1:0]  acc_b,
  input  logic [4:0]     c5,
  input  logic [AW-1:0]  ofs,
  output logic [AW-1:0]  inter,
  output logic [AW-1:0]  wb_val
);
  logic [AW-1:0] root;
  logic [AW-1:0] addend;

  assign root = dec.pc_rel ? pc : auto_addr(base, dec.wb);

  always_comb begin
    case (dec.add)
      ADD_C5:  addend = sext_five(c5);
      ADD_A:   addend = sext_byte(acc_a);
      ADD_B:   addend = sext_byte(acc_b);
      ADD_D:   addend = {acc_a, acc_b};
      ADD_OFS: addend = ofs;
      default: addend = '0;
    endcase
  end

  assign inter  = (dec.add == ADD_EXT) ? ofs : root + addend;
  assign wb_val = step_base(base, dec.wb);
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    postbyte,
  input  logic [15:0]   reg_x,
  input  logic [15:0]   reg_y,
  input  logic [15:0]   reg_u,
  input  logic [15:0]   reg_s,
  input  logic [7:0]    acc_a,
  input  logic [7:0]    acc_b,
  input  logic [15:0]   pc_in,
  output logic          mem_req,
  output logic [15:0]   mem_addr,
  input  logic          mem_valid,
  input  logic [7:0]    mem_data,
  output logic          done,
  output logic [15:0]   ea,
  output logic          illegal,
  output logic [15:0]   pc_out,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [15:0]   wb_val
);
  typedef enum logic [2:0] {
    S_IDLE, S_OFS1, S_OFS2, S_CALC, S_PTR1, S_PTR2, S_FIN
  } st_e;

  st_e           state;
  logic [7:0]    pb_q;
  logic [AW-1:0] base_q, pc_q, ofs_q, inter_q, ea_q, wbv_q;
  logic [BW-1:0] a_q, b_q;

  logic [7:0]    pb_sel;
  dec_t          dec;
  logic [AW-1:0] base_now, inter_c, wbv_c;

  // named internal events
  logic accept_ev, byte_ev, finish_ev;

  assign pb_sel    = (state == S_IDLE) ? postbyte : pb_q;
  assign accept_ev = (state == S_IDLE) && start;
  assign byte_ev   = mem_req && mem_valid;
  assign finish_ev = (state == S_FIN);

  idx_decode u_dec (.pb(pb_sel), .dec(dec));

  idx_base_sel u_base (
    .regs_flat({reg_s, reg_u, reg_y, reg_x}),
    .sel(pb_sel[6:5]),
    .base(base_now)
  );

  idx_ea_adder u_add (
    .dec(dec), .base(base_q), .pc(pc_q), .acc_a(a_q), .acc_b(b_q),
    .c5(pb_q[4:0]), .ofs(ofs_q), .inter(inter_c), .wb_val(wbv_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pb_q    <= '0;
      base_q  <= '0;
      pc_q    <= '0;
      ofs_q   <= '0;
      inter_q <= '0;
      ea_q    <= '0;
      wbv_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pb_q   <= postbyte;
          base_q <= base_now;
          pc_q   <= pc_in;
          a_q    <= acc_a;
          b_q    <= acc_b;
          ofs_q  <= '0;
          if (dec.illegal)          state <= S_FIN;
          else if (dec.nbytes != 0) state <= S_OFS1;
          else                      state <= S_CALC;
        end
        S_OFS1: if (byte_ev) begin
          pc_q <= pc_q + AW'(1);
          if (dec.nbytes == 2'd2) begin
            ofs_q[AW-1:BW] <= mem_data;
            state          <= S_OFS2;
          end else begin
            ofs_q <= sext_byte(mem_data);
            state <= S_CALC;
          end
        end
        S_OFS2: if (byte_ev) begin
          pc_q         <= pc_q + AW'(1);
          ofs_q[BW-1:0] <= mem_data;
          state        <= S_CALC;
        end
        S_CALC: begin
          inter_q <= inter_c;
          wbv_q   <= wbv_c;
          ea_q    <= inter_c;
          state   <= dec.indirect ? S_PTR1 : S_FIN;
        end
        S_PTR1: if (byte_ev) begin
          ea_q[AW-1:BW] <= mem_data;
          state         <= S_PTR2;
        end
        S_PTR2: if (byte_ev) begin
          ea_q[BW-1:0] <= mem_data;
          state        <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_OFS1, S_OFS2: mem_addr = pc_q;
      S_PTR1:         mem_addr = inter_q;
      S_PTR2:         mem_addr = inter_q + AW'(1);
      default:        mem_addr = '0;
    endcase
  end

  assign mem_req = (state == S_OFS1) || (state == S_OFS2) ||
                   (state == S_PTR1) || (state == S_PTR2);
  assign done    = finish_ev;
  assign illegal = finish_ev && dec.illegal;
  assign ea      = ea_q;
  assign pc_out  = pc_q;
  assign wb_en   = finish_ev && !dec.illegal && (dec.wb != WB_NONE);
  assign wb_sel  = pb_q[6:5];
  assign wb_val  = wbv_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
  // R5
  wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && !illegal));
  // R8
  illegal_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!$past(mem_req) && !wb_en));
  // R9
  start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !accept_ev);
endmodule

// File: tb/sim_idx_ea_unit.sv
module sim_idx_ea_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] postbyte = '0;
  logic [15:0] reg_x = '0, reg_y = '0, reg_u = '0, reg_s = '0, pc_in = '0;
  logic [7:0] acc_a = '0, acc_b = '0;
  logic mem_req, mem_valid = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0] mem_data = '0;
  logic done, illegal, wb_en;
  logic [15:0] ea, pc_out, wb_val;
  logic [1:0] wb_sel;

  int n_chk = 0;
  int n_err = 0;
  int seed_dummy;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
    .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u), .reg_s(reg_s),
    .acc_a(acc_a), .acc_b(acc_b), .pc_in(pc_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .done(done), .ea(ea), .illegal(illegal), .pc_out(pc_out),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
  );

  // memory contents computed from the address
  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] mword(input logic [15:0] a);
    return {mbyte(a), mbyte(a + 16'd1)};
  endfunction

  function automatic logic [15:0] sx8(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected results
  logic        e_ill, e_wb;
  logic [15:0] e_ea, e_pc, e_wbv;
  int          e_reads;

  task automatic model(input logic [7:0] pb);
    logic [15:0] base, addr, o;
    logic [3:0] md;
    int nb;
    case (pb[6:5])
      2'd0: base = reg_x;
      2'd1: base = reg_y;
      2'd2: base = reg_u;
      default: base = reg_s;
    endcase
    e_ill = 0; e_wb = 0; e_wbv = base; nb = 0; addr = base;
    md = pb[3:0];
    if (!pb[7]) begin
      addr = base + {{11{pb[4]}}, pb[4:0]};
    end else begin
      case (md)
        4'd0: begin e_ill = pb[4]; e_wb = 1; e_wbv = base + 16'd1; end
        4'd1: begin e_wb = 1; e_wbv = base + 16'd2; end
        4'd2: begin e_ill = pb[4]; e_wb = 1; e_wbv = base - 16'd1; addr = e_wbv; end
        4'd3: begin e_wb = 1; e_wbv = base - 16'd2; addr = e_wbv; end
        4'd4: addr = base;
        4'd5: addr = base + sx8(acc_b);
        4'd6: addr = base + sx8(acc_a);
        4'd11: addr = base + {acc_a, acc_b};
        4'd8: begin nb = 1; addr = base + sx8(mbyte(pc_in)); end
        4'd9: begin nb = 2; addr = base + mword(pc_in); end
        4'd12: begin nb = 1; addr = pc_in + 16'd1 + sx8(mbyte(pc_in)); end
        4'd13: begin nb = 2; addr = pc_in + 16'd2 + mword(pc_in); end
        4'd15: if (pb == 8'h9F) begin nb = 2; addr = mword(pc_in); end
               else e_ill = 1;
        default: e_ill = 1;
      endcase
    end
    if (e_ill) begin
      nb = 0; e_wb = 0;
    end
    e_reads = nb;
    e_ea = addr;
    if (pb[7] && pb[4] && !e_ill) begin
      e_ea = mword(addr);
      e_reads += 2;
    end
    e_pc = pc_in + 16'(nb);
  endtask

  task automatic run_one(input logic [7:0] pb, input bit junk);
    int reads = 0;
    int wait_c = $urandom % 3;
    bit seen = 0;
    bit stray_wb = 0;
    model(pb);
    postbyte = pb;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 60; k++) begin
      if (done) begin seen = 1; break; end
      if (wb_en) stray_wb = 1;
      if (k == 0 && junk) begin
        start = 1; postbyte = 8'h86;
        reg_x = ~reg_x; reg_y = ~reg_y; reg_u = ~reg_u; reg_s = ~reg_s;
        pc_in = pc_in ^ 16'h1234; acc_a = ~acc_a; acc_b = ~acc_b;
      end else if (k == 1) begin
        start = 0;
      end
      if (mem_valid) begin
        mem_valid = 0;
        wait_c = $urandom % 3;
      end else if (mem_req) begin
        if (wait_c == 0) begin
          mem_valid = 1; mem_data = mbyte(mem_addr); reads++;
        end else wait_c--;
      end
      @(negedge clk);
    end
    start = 0;
    mem_valid = 0;
    chk(seen, "R9", "done seen (watchdog)", 32'(seen), 1);
    if (seen) begin
      chk(illegal == e_ill, "R8", $sformatf("illegal pb=%0h", pb), 32'(illegal), 32'(e_ill));
      if (!e_ill) begin
        if (!pb[7]) chk(ea == e_ea, "R1", $sformatf("ea pb=%0h", pb), ea, e_ea);
        else if (pb == 8'h9F) chk(ea == e_ea, "R7", "ea ext-ind", ea, e_ea);
        else if (pb[4]) chk(ea == e_ea, "R6", $sformatf("ea pb=%0h", pb), ea, e_ea);
        else if (pb[3:2] == 2'b11) chk(ea == e_ea, "R4", $sformatf("ea pb=%0h", pb), ea, e_ea);
        else if (pb[3]) chk(ea == e_ea, "R3", $sformatf("ea pb=%0h", pb), ea, e_ea);
        else chk(ea == e_ea, "R2", $sformatf("ea pb=%0h", pb), ea, e_ea);
      end
      chk(pc_out == e_pc, "R3", $sformatf("pc_out pb=%0h", pb), pc_out, e_pc);
      chk(reads == e_reads, "R8", $sformatf("read count pb=%0h", pb), reads, e_reads);
      chk(wb_en == e_wb, "R5", $sformatf("wb_en pb=%0h", pb), 32'(wb_en), 32'(e_wb));
      if (e_wb) begin
        chk(wb_val == e_wbv, "R5", $sformatf("wb_val pb=%0h", pb), wb_val, e_wbv);
        chk(wb_sel == pb[6:5], "R5", "wb_sel", 32'(wb_sel), 32'(pb[6:5]));
      end
      chk(!stray_wb, "R5", "wb_en outside done", 32'(stray_wb), 0);
      @(negedge clk);
      chk(!done, "R9", "done one cycle", 32'(done), 0);
    end
  endtask

  task automatic rand_regs();
    reg_x = 16'($urandom); reg_y = 16'($urandom);
    reg_u = 16'($urandom); reg_s = 16'($urandom);
    acc_a = 8'($urandom);  acc_b = 8'($urandom);
    pc_in = 16'($urandom);
  endtask

  initial begin
    seed_dummy = $urandom(32'd7);
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !wb_en, "R9", "reset outputs idle",
        {29'd0, done, mem_req, wb_en}, 0);
    rst_n = 1;
    @(negedge clk);
    // directed corners
    reg_x = 16'h1000; reg_y = 16'h2000; reg_u = 16'h3000; reg_s = 16'h4000;
    acc_a = 8'h80; acc_b = 8'hFF; pc_in = 16'h0100;
    run_one(8'h04, 0);   // R1 +4 on X
    run_one(8'h1F, 0);   // R1 -1 on X
    run_one(8'h70, 0);   // R1 -16 on S
    run_one(8'h85, 0);   // R2 B sign-extended
    run_one(8'hA6, 0);   // R2 A sign-extended on Y
    run_one(8'hCB, 0);   // R2 D on U
    run_one(8'h88, 0);   // R3
    run_one(8'h89, 1);   // R3, start ignored while busy (R9)
    run_one(8'h8C, 0);   // R4
    run_one(8'hED, 0);   // R4 bits 6:5 ignored
    run_one(8'h80, 0);   // R5 post +1
    run_one(8'hE3, 0);   // R5 pre -2 on S
    run_one(8'h91, 1);   // R6 indirect post +2, wb with done
    run_one(8'hB3, 0);   // R6 indirect pre -2
    run_one(8'h9F, 0);   // R7
    run_one(8'h90, 0);   // R8
    run_one(8'hF2, 0);   // R8
    run_one(8'h87, 0);   // R8
    run_one(8'hBF, 0);   // R8 1111 not 9F
    run_one(8'h8E, 0);   // R8
    reg_s = 16'h0001;
    run_one(8'hE3, 0);   // R5 wrap below zero
    reg_x = 16'hFFFF;
    run_one(8'h81, 0);   // R5 wrap above max
    for (int i = 0; i < 400; i++) begin
      rand_regs();
      run_one(8'($urandom), (i % 5) == 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule